// File: doc/BRIEF.md
# Shortened BCH Framing Controller

This block sequences a bit-serial transmit path in which a scrambler feeds a shortened (N, K) BCH encoder, with N = 63 and K = 51 by default. A frame starts when `start_i` pulses with a nonzero payload length in bits on `len_i`. From then on, every cycle in which `adv_i` is high consumes one codeword position. Positions 0 to K-1 of each codeword are data slots. Positions K to N-1 are parity slots, where the scrambler is held and the encoder is told to emit its check bits.

When the payload runs out partway through a codeword, the remaining data slots of that codeword carry stuffed zero bits. The frame then closes at the end of that codeword, after its parity. A second modulo counter counts every emitted bit in interleaver blocks of BLK = 192 bits. When the frame ends, the block reports two figures: how many pad bits were stuffed, and how many bits fill the final, possibly short, interleaver block. The BCH arithmetic, the scrambler and the interleaver are outside this block and see only its strobes.

Top module: `bchfc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the following to 0: `busy_o`, `done_o`, every strobe, `pad_o` and `last_blk_o`.
- R2: `start_i` with a nonzero `len_i` while idle launches a frame, and `busy_o` is high from the next cycle. `start_i` is ignored while a frame runs, and it is also ignored when `len_i` is 0.
- R3: Each cycle of a frame with `adv_i` high consumes one position. `par_sel_o` is high exactly while the current position is K or above. After position N-1 the count returns to 0.
- R4: `scr_take_o` is high only on a data slot with `adv_i` high while payload bits remain. Over a frame it pulses exactly `len_i` times.
- R5: While a frame runs, `scr_stall_o` is high whenever the current position is a parity slot or the payload is exhausted.
- R6: `stuff_o` is high on each data slot with `adv_i` high after the payload is exhausted. Its pulse count, ceil(L/K)*K - L, appears on `pad_o` when the frame ends.
- R7: A frame lasts exactly ceil(L/K) codewords, that is ceil(L/K)*N consumed positions.
- R8: At frame end `last_blk_o` equals ((T-1) mod BLK)+1, where T is the frame's bit total. It therefore reads BLK when T is a multiple of BLK.
- R9: `done_o` is a one-cycle pulse in the cycle after the final parity bit, and `busy_o` is low in that same cycle.
- R10: A frame cycle with `adv_i` low asserts neither `scr_take_o` nor `stuff_o`, and no position is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame launch pulse |
| len_i | input | LEN_W | Payload length in bits |
| adv_i | input | 1 | Consume one codeword position this cycle |
| busy_o | output | 1 | Frame in progress |
| scr_take_o | output | 1 | Scrambler delivers a payload bit |
| scr_stall_o | output | 1 | Scrambler held |
| stuff_o | output | 1 | Encoder receives a stuffed zero |
| par_sel_o | output | 1 | Encoder emits parity |
| done_o | output | 1 | Frame finished pulse |
| pad_o | output | $clog2(K+1) | Pad bits stuffed in the last frame |
| last_blk_o | output | $clog2(BLK+1) | Bits in the last interleaver block |

## Verification
The bench builds the block with its default parameters: N = 63, K = 51, BLK = 192 and LEN_W = 16. With these values, lengths of 1 to 64 codewords cover three cases: a single short codeword, an exact fill of three codewords (189 bits, just short of one block), and a 64-codeword frame of 4032 bits, which is exactly 21 blocks and exercises the full-size final block. Some frames hold `adv_i` low on alternate cycles, so that the freeze behaviour is checked in every codeword phase.

// File: rtl/bchfc_pkg.sv
package bchfc_pkg;

    // Role of the current codeword position.
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_DATA   = 2'd1,
        SLOT_STUFF  = 2'd2,
        SLOT_PARITY = 2'd3
    } slot_e;

endpackage

// File: rtl/bchfc_modcnt.sv
module bchfc_modcnt #(
    parameter int MOD = 63,
    parameter int W   = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == TOP);

endmodule

// File: rtl/bchfc_tally.sv
module bchfc_tally #(
    parameter int K      = 51,
    parameter int BLK    = 192,
    parameter int PAD_W  = $clog2(K + 1),
    parameter int BLK_W  = $clog2(BLK),
    parameter int SIZE_W = $clog2(BLK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stuff_bit,
    input  logic              fin,
    input  logic [BLK_W-1:0]  blk_cnt,
    input  logic              blk_last,
    output logic [PAD_W-1:0]  pad_o,
    output logic [SIZE_W-1:0] size_o
);

    typedef struct packed {
        logic [PAD_W-1:0]  stuffed;
        logic [PAD_W-1:0]  pad;
        logic [SIZE_W-1:0] size;
    } tally_t;

    tally_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.stuffed = '0;
        end else if (stuff_bit) begin
            t_d.stuffed = t_q.stuffed + 1'b1;
        end
        if (fin) begin
            // Final bit sits in a parity slot, so the stuffed count is settled.
            t_d.pad  = t_q.stuffed;
            t_d.size = blk_last ? SIZE_W'(BLK) : SIZE_W'(blk_cnt) + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign pad_o  = t_q.pad;
    assign size_o = t_q.size;

endmodule

// File: rtl/bchfc_ctrl.sv
module bchfc_ctrl #(
    parameter int N      = 63,
    parameter int K      = 51,
    parameter int BLK    = 192,
    parameter int LEN_W  = 16,
    parameter int PAD_W  = $clog2(K + 1),
    parameter int SIZE_W = $clog2(BLK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              adv_i,
    output logic              busy_o,
    output logic              scr_take_o,
    output logic              scr_stall_o,
    output logic              stuff_o,
    output logic              par_sel_o,
    output logic              done_o,
    output logic [PAD_W-1:0]  pad_o,
    output logic [SIZE_W-1:0] last_blk_o
);

    import bchfc_pkg::*;

    localparam int POS_W = $clog2(N);
    localparam int BLK_W = $clog2(BLK);
    localparam logic [POS_W-1:0] DATA_END = POS_W'(K - 1);

    typedef struct packed {
        logic             run;
        logic             ctl;
        logic [LEN_W-1:0] rem;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    logic [POS_W-1:0] pos_cnt;
    logic             pos_last;
    logic [BLK_W-1:0] blk_cnt;
    logic             blk_last;
    logic             launch;
    logic             step;
    logic             fin;
    logic             ctl_flag;
    slot_e            slot;

    assign launch   = start_i && !st_q.run && (len_i != '0);
    assign step     = st_q.run && adv_i;
    assign ctl_flag = st_q.ctl;

    always_comb begin
        if (!st_q.run)            slot = SLOT_IDLE;
        else if (st_q.ctl)        slot = SLOT_PARITY;
        else if (st_q.rem == '0)  slot = SLOT_STUFF;
        else                      slot = SLOT_DATA;
    end

    assign fin = step && pos_last && (st_q.rem == '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = fin;
        if (launch) begin
            st_d.run = 1'b1;
            st_d.ctl = 1'b0;
            st_d.rem = len_i;
        end else if (step) begin
            if (slot == SLOT_DATA) st_d.rem = st_q.rem - 1'b1;
            if (pos_cnt == DATA_END) st_d.ctl = 1'b1;
            else if (pos_last)       st_d.ctl = 1'b0;
            if (fin)                 st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    bchfc_modcnt #(.MOD(N), .W(POS_W)) u_pos (
        .clk    (clk),
        .rst    (rst),
        .clr    (launch),
        .inc    (step),
        .cnt_o  (pos_cnt),
        .last_o (pos_last)
    );

    bchfc_modcnt #(.MOD(BLK), .W(BLK_W)) u_blk (
        .clk    (clk),
        .rst    (rst),
        .clr    (launch),
        .inc    (step),
        .cnt_o  (blk_cnt),
        .last_o (blk_last)
    );

    bchfc_tally #(.K(K), .BLK(BLK), .PAD_W(PAD_W), .BLK_W(BLK_W), .SIZE_W(SIZE_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .start     (launch),
        .stuff_bit (adv_i && (slot == SLOT_STUFF)),
        .fin       (fin),
        .blk_cnt   (blk_cnt),
        .blk_last  (blk_last),
        .pad_o     (pad_o),
        .size_o    (last_blk_o)
    );

    assign busy_o      = st_q.run;
    assign done_o      = st_q.done;
    assign par_sel_o   = (slot == SLOT_PARITY);
    assign scr_stall_o = (slot == SLOT_PARITY) || (slot == SLOT_STUFF);
    assign scr_take_o  = adv_i && (slot == SLOT_DATA);
    assign stuff_o     = adv_i && (slot == SLOT_STUFF);

endmodule

// File: rtl/bchfc_chk.sv
module bchfc_chk #(
    parameter int N     = 63,
    parameter int K     = 51,
    parameter int POS_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic             adv_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             scr_take_o,
    input logic             scr_stall_o,
    input logic             stuff_o,
    input logic [POS_W-1:0] pos,
    input logic             ctl
);

    // R3: the parity flag agrees with the position counter
    a_r3_flag_tracks_pos: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (ctl == (pos >= POS_W'(K))));

    // R3: wrap after the last position
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (busy_o && adv_i && pos == POS_W'(N - 1)) |=> (pos == '0));

    // R10: no advance without adv_i
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !adv_i) |=> ($stable(pos) && $stable(ctl)));

    // R4: payload only in data slots
    a_r4_take_data: assert property (@(posedge clk) disable iff (rst)
        scr_take_o |-> (!ctl && adv_i && !scr_stall_o));

    // R6: stuffing and payload never coincide
    a_r6_stuff_excl: assert property (@(posedge clk) disable iff (rst)
        !(scr_take_o && stuff_o));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: done only once the frame is closed
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

bind bchfc_ctrl bchfc_chk #(.N(N), .K(K), .POS_W($clog2(N))) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adv_i       (adv_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .scr_take_o  (scr_take_o),
    .scr_stall_o (scr_stall_o),
    .stuff_o     (stuff_o),
    .pos         (pos_cnt),
    .ctl         (ctl_flag)
);

// File: tb/sim_bchfc_ctrl.sv
module sim_bchfc_ctrl;

    localparam int N = 63;
    localparam int K = 51;
    localparam int BLK = 192;
    localparam int LEN_W = 16;

    typedef struct packed {
        int len;
        int ncw;
        int pad;
        int last;
        int gap;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1,    1,  50, 63,  0},
        '{51,   1,  0,  63,  0},
        '{52,   2,  50, 126, 1},
        '{102,  2,  0,  126, 0},
        '{153,  3,  0,  189, 0},
        '{154,  4,  50, 60,  0},
        '{200,  4,  4,  60,  1},
        '{204,  4,  0,  60,  0},
        '{612,  12, 0,  180, 0},
        '{1000, 20, 20, 108, 0},
        '{3264, 64, 0,  192, 0},
        '{3263, 64, 1,  192, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic adv_i = 1'b0;
    logic busy_o, scr_take_o, scr_stall_o, stuff_o, par_sel_o, done_o;
    logic [$clog2(K+1)-1:0] pad_o;
    logic [$clog2(BLK+1)-1:0] last_blk_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    bchfc_ctrl #(.N(N), .K(K), .BLK(BLK), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .adv_i(adv_i),
        .busy_o(busy_o), .scr_take_o(scr_take_o), .scr_stall_o(scr_stall_o),
        .stuff_o(stuff_o), .par_sel_o(par_sel_o), .done_o(done_o),
        .pad_o(pad_o), .last_blk_o(last_blk_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Runs one frame; poke pulses start mid-frame to check it is ignored.
    task automatic run_frame(input vec_t v, input bit poke);
        int takes = 0, stuffs = 0, pars = 0, bits = 0, pos_m = 0;
        int mism = 0, idle_bad = 0;
        bit seen = 0;
        @(negedge clk);
        start_i = 1'b1; len_i = LEN_W'(v.len); adv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
        for (int c = 0; c < 20000; c++) begin
            adv_i = (v.gap != 0) ? c[0] : 1'b1;
            start_i = poke && (c == 10);
            len_i = poke ? LEN_W'(1) : LEN_W'(v.len);
            #1;
            if (done_o) begin
                seen = 1;
                break;
            end
            begin
                int rem_m = v.len - takes;
                bit par_e = (pos_m >= K);
                bit stall_e = par_e || (rem_m == 0);
                if (par_sel_o !== par_e || scr_stall_o !== stall_e) mism++;
                if (adv_i) begin
                    if (scr_take_o !== (!par_e && rem_m > 0)) mism++;
                    if (stuff_o !== (!par_e && rem_m == 0)) mism++;
                    takes += int'(scr_take_o);
                    stuffs += int'(stuff_o);
                    pars += int'(par_sel_o);
                    bits++;
                    pos_m = (pos_m + 1) % N;
                end else if (scr_take_o || stuff_o) begin
                    idle_bad++;
                end
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        adv_i = 1'b0;
        chk(seen, "R9 done reached", int'(seen), 1);
        chk(busy_o === 1'b0, "R9 busy low with done", int'(busy_o), 0);
        chk(mism == 0, "R3/R5 slot timing (R3 R5)", mism, 0);
        chk(idle_bad == 0, "R10 no strobe with adv low", idle_bad, 0);
        chk(takes == v.len, "R4 payload pulses", takes, v.len);
        chk(stuffs == v.pad, "R6 stuff pulses", stuffs, v.pad);
        chk(pars == v.ncw * (N - K), "R3 parity bits", pars, v.ncw * (N - K));
        chk(bits == v.ncw * N, "R7 frame bits", bits, v.ncw * N);
        chk(int'(pad_o) == v.pad, "R6 pad_o", int'(pad_o), v.pad);
        chk(int'(last_blk_o) == v.last, "R8 last block size", int'(last_blk_o), v.last);
        @(negedge clk);
        #1;
        chk(done_o === 1'b0, "R9 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1 reset idle", int'(busy_o), 0);
        chk(pad_o == '0 && last_blk_o == '0, "R1 reset results", int'(last_blk_o), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0);

        // R2: start ignored during a frame
        run_frame('{52, 2, 50, 126, 0}, 1'b1);

        // R2: zero length is ignored
        @(negedge clk);
        start_i = 1'b1; len_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk(busy_o === 1'b0, "R2 zero length ignored", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        #1;
        chk(done_o === 1'b0, "R2 no done for zero length", int'(done_o), 0);

        // R1: reset in the middle of a frame
        @(negedge clk);
        start_i = 1'b1; len_i = LEN_W'(100);
        @(negedge clk);
        start_i = 1'b0; adv_i = 1'b1;
        repeat (55) @(negedge clk);
        #1;
        chk(par_sel_o === 1'b1, "R3 parity mid frame", int'(par_sel_o), 1);
        rst = 1'b1; adv_i = 1'b0;
        @(negedge clk);
        #1;
        chk(busy_o === 1'b0 && par_sel_o === 1'b0 && scr_stall_o === 1'b0,
            "R1 reset mid frame", int'(busy_o), 0);
        chk(pad_o == '0 && last_blk_o == '0, "R1 reset clears results", int'(last_blk_o), 0);
        rst = 1'b0;
        run_frame('{51, 1, 0, 63, 0}, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule